// File: doc/BRIEF.md
# Flow-Control Frame Transmit Arbiter

This block sits on the byte-wide transmit path of an Ethernet MAC. It merges locally generated flow-control (PAUSE) frames with the ordinary frames a client sends. The client raises a one-cycle request strobe together with a 16-bit pause quantum. The block keeps a single pending request. It waits until any client frame already on the wire has sent its final byte, then emits a complete 64-byte control frame with its FCS. Only after that does it accept the next client frame. The frame is emitted even while an external hold input is blocking client traffic.

The client side is a valid/ready byte stream. A byte transfers on a cycle where `cli_valid`, `cli_ready` and `ce` are all high. `cli_ready` is low whenever a control frame owns the output and whenever `ce` is low. It is also low while `tx_hold` is high and no client frame is in progress. A client must keep `cli_data`/`cli_last` stable until the byte is taken. The MAC side has no back-pressure. `mac_valid` marks the cycles that carry a byte, and those cycles are always clock-enable cycles. Client bytes pass through combinationally in the same cycle.

Top module: `pause_tx_arbiter`

## Requirements
- R1: On a clock-enable cycle with `fc_en` high and `pause_req` high, the value on `pause_val` is stored. It appears in frame bytes 16 (high byte) and 17 (low byte) of the next control frame.
- R2: A client frame in progress is never interrupted. A stored request is served immediately after that frame's last byte, before any further client frame starts.
- R3: Only one request is stored. Several strobes before the frame starts yield exactly one control frame, which carries the most recent quantum.
- R4: While `tx_hold` is high, no new client frame starts (`cli_ready` low when idle), but a stored request is still sent.
- R5: The control frame is 64 bytes: bytes 0-5 are 01 80 C2 00 00 01, bytes 6-11 are `src_mac` most significant byte first, bytes 12-13 are 88 08, bytes 14-15 are 00 01, and bytes 18-59 are zero. `mac_last` is high on byte 63 only.
- R6: Bytes 60-63 are the FCS, sent least significant byte first. The FCS is the bitwise complement of the reflected CRC-32 (polynomial 0x04C11DB7, initial value all ones) over bytes 0-59.
- R7: On cycles with `ce` low, `mac_valid` and `cli_ready` are low and no state advances. A control frame spread over gated cycles is byte-for-byte the same as an ungated one.
- R8: With `fc_en` low, strobes are ignored and any stored request is dropped. Client frames pass through unchanged: same data and `mac_last`, with `mac_valid` equal to the client handshake.
- R9: `cli_ready` stays low for the whole control frame. A strobe accepted during a control frame produces a second control frame right after the first.
- R10: After reset, `mac_valid` is low, no request is stored, and `cli_ready` follows `ce` and `tx_hold`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Clock enable; all transfers and state changes occur only when high |
| fc_en | input | 1 | Flow-control enable; when low, pause requests are ignored |
| tx_hold | input | 1 | Paused state; blocks the start of client frames only |
| src_mac | input | 48 | Source address placed in control frames |
| pause_req | input | 1 | Pause request strobe |
| pause_val | input | 16 | Pause quantum sampled with the strobe |
| cli_data | input | 8 | Client byte |
| cli_valid | input | 1 | Client byte valid |
| cli_last | input | 1 | Client byte is the final byte of its frame |
| cli_ready | output | 1 | Client byte accepted this cycle when valid |
| mac_data | output | 8 | Byte toward the MAC |
| mac_valid | output | 1 | `mac_data` carries a byte this cycle |
| mac_last | output | 1 | Final byte of the current output frame |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle:
- gated cycles are silent and frozen;
- the client is held off for the whole control frame;
- a client frame in progress is never overlapped by a control frame;
- the hold input keeps new frames from starting;
- every control frame ends at its last byte;
- disabling flow control clears the stored request.

Only the bench scenarios can show the content and order of whole frames:
- the exact header, pad and FCS bytes;
- which quantum survives several strobes;
- that a queued client frame follows the control frame;
- that a strobe during a frame yields a second frame.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam logic [47:0] CTRL_DEST_ADDR = 48'h0180C2000001;
  localparam logic [15:0] CTRL_ETHERTYPE = 16'h8808;
  localparam logic [15:0] CTRL_OPCODE    = 16'h0001;
  localparam logic [31:0] CRC_POLY_REFL  = 32'hEDB88320;
  localparam int          HDR_BYTES      = 14;
  localparam int          FCS_BYTES      = 4;

  typedef enum logic [1:0] {
    LANE_IDLE   = 2'd0,
    LANE_CLIENT = 2'd1,
    LANE_PAUSE  = 2'd2
  } lane_e;

  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/pause_req_latch.sv
module pause_req_latch #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          fc_en,
  input  logic          req,
  input  logic [QW-1:0] quanta,
  input  logic          take,
  output logic          pending,
  output logic [QW-1:0] quanta_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      quanta_q <= '0;
    end else if (ce) begin
      if (!fc_en) begin
        pending <= 1'b0;
      end else if (req) begin
        pending  <= 1'b1;
        quanta_q <= quanta;
      end else if (take) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
  import pause_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 46,
  parameter int QW            = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          active,
  input  logic [47:0]   src_mac,
  input  logic [QW-1:0] quanta,
  output logic [7:0]    byte_o,
  output logic          last_o,
  output logic          mid_o
);
  localparam int BODY  = HDR_BYTES + PAYLOAD_BYTES;
  localparam int TOTAL = BODY + FCS_BYTES;
  localparam int CW    = $clog2(TOTAL);

  logic [CW-1:0]  cnt;
  logic [QW-1:0]  q_frame;
  logic [31:0]    crc_q;
  logic [31:0]    fcs;
  int             idx;

  assign fcs    = ~crc_q;
  assign last_o = (cnt == CW'(TOTAL - 1));
  assign mid_o  = (cnt != '0);

  always_comb begin
    idx = int'(cnt);
    if (idx < 6)            byte_o = CTRL_DEST_ADDR[8*(5 - idx) +: 8];
    else if (idx < 12)      byte_o = src_mac[8*(11 - idx) +: 8];
    else if (idx == 12)     byte_o = CTRL_ETHERTYPE[15:8];
    else if (idx == 13)     byte_o = CTRL_ETHERTYPE[7:0];
    else if (idx == 14)     byte_o = CTRL_OPCODE[15:8];
    else if (idx == 15)     byte_o = CTRL_OPCODE[7:0];
    else if (idx == 16)     byte_o = q_frame[15:8];
    else if (idx == 17)     byte_o = q_frame[7:0];
    else if (idx < BODY)    byte_o = 8'h00;
    else                    byte_o = fcs[8*(idx - BODY) +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      q_frame <= '0;
      crc_q   <= '1;
    end else if (ce && active) begin
      cnt <= last_o ? '0 : cnt + 1'b1;
      if (cnt == '0) begin
        q_frame <= quanta;
        crc_q   <= crc32_step(32'hFFFF_FFFF, byte_o);
      end else if (idx < BODY) begin
        crc_q   <= crc32_step(crc_q, byte_o);
      end
    end
  end
endmodule

// File: rtl/pause_tx_mux.sv
module pause_tx_mux
  import pause_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic tx_hold,
  input  logic pending,
  input  logic pause_last,
  input  logic cli_valid,
  input  logic cli_last,
  output logic cli_ready,
  output logic pause_act,
  output logic in_client,
  output logic take
);
  lane_e lane;

  assign in_client = (lane == LANE_CLIENT);
  assign pause_act = (lane == LANE_PAUSE) || ((lane == LANE_IDLE) && pending);
  assign cli_ready = ce && !pause_act && (in_client || !tx_hold);
  assign take      = ce && (lane == LANE_IDLE) && pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane <= LANE_IDLE;
    end else if (ce) begin
      case (lane)
        LANE_IDLE: begin
          if (pending)                                 lane <= LANE_PAUSE;
          else if (cli_valid && cli_ready && !cli_last) lane <= LANE_CLIENT;
        end
        LANE_CLIENT: if (cli_valid && cli_last)        lane <= LANE_IDLE;
        LANE_PAUSE:  if (pause_last)                   lane <= LANE_IDLE;
        default:                                       lane <= LANE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pause_tx_arbiter.sv
module pause_tx_arbiter #(
  parameter int PAYLOAD_BYTES = 46,
  parameter int QW            = 16,
  parameter int DW            = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          fc_en,
  input  logic          tx_hold,
  input  logic [47:0]   src_mac,
  input  logic          pause_req,
  input  logic [QW-1:0] pause_val,
  input  logic [DW-1:0] cli_data,
  input  logic          cli_valid,
  input  logic          cli_last,
  output logic          cli_ready,
  output logic [DW-1:0] mac_data,
  output logic          mac_valid,
  output logic          mac_last
);
  logic          pending;
  logic [QW-1:0] quanta_q;
  logic          take;
  logic          pause_act;
  logic          in_client;
  logic [7:0]    gen_byte;
  logic          gen_last;
  logic          gen_mid;

  pause_req_latch #(.QW(QW)) u_latch (
    .clk(clk), .rst_n(rst_n), .ce(ce), .fc_en(fc_en),
    .req(pause_req), .quanta(pause_val), .take(take),
    .pending(pending), .quanta_q(quanta_q)
  );

  pause_frame_gen #(.PAYLOAD_BYTES(PAYLOAD_BYTES), .QW(QW)) u_gen (
    .clk(clk), .rst_n(rst_n), .ce(ce), .active(pause_act),
    .src_mac(src_mac), .quanta(quanta_q),
    .byte_o(gen_byte), .last_o(gen_last), .mid_o(gen_mid)
  );

  pause_tx_mux u_mux (
    .clk(clk), .rst_n(rst_n), .ce(ce), .tx_hold(tx_hold),
    .pending(pending), .pause_last(gen_last),
    .cli_valid(cli_valid), .cli_last(cli_last),
    .cli_ready(cli_ready), .pause_act(pause_act),
    .in_client(in_client), .take(take)
  );

  assign mac_valid = ce && (pause_act || (cli_valid && cli_ready));
  assign mac_data  = pause_act ? DW'(gen_byte) : cli_data;
  assign mac_last  = pause_act ? gen_last : cli_last;
endmodule

// File: rtl/pause_tx_arbiter_chk.sv
module pause_tx_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic ce,
  input logic fc_en,
  input logic tx_hold,
  input logic cli_ready,
  input logic mac_valid,
  input logic mac_last,
  input logic pause_act,
  input logic in_client,
  input logic pending,
  input logic gen_mid
);
  a_r7_gated_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |-> (!mac_valid && !cli_ready));

  a_r7_gated_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(gen_mid) && $stable(in_client)));

  a_r9_client_held_off: assert property (@(posedge clk) disable iff (!rst_n)
    pause_act |-> !cli_ready);

  a_r9_frame_owns_lane: assert property (@(posedge clk) disable iff (!rst_n)
    gen_mid |-> pause_act);

  a_r2_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    in_client |-> !pause_act);

  a_r4_hold_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_hold && !in_client) |-> !cli_ready);

  a_r5_frame_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && pause_act && mac_last) |=> !gen_mid);

  a_r8_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !fc_en) |=> !pending);
endmodule

bind pause_tx_arbiter pause_tx_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .fc_en(fc_en), .tx_hold(tx_hold),
  .cli_ready(cli_ready), .mac_valid(mac_valid), .mac_last(mac_last),
  .pause_act(pause_act), .in_client(in_client), .pending(pending),
  .gen_mid(gen_mid)
);

// File: tb/sim_pause_tx_arbiter.sv
`timescale 1ns/1ps
module sim_pause_tx_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b1;
  logic        fc_en = 1'b1;
  logic        tx_hold = 1'b0;
  logic [47:0] src_mac = 48'h02AB_CD01_2345;
  logic        pause_req = 1'b0;
  logic [15:0] pause_val = 16'h0;
  logic [7:0]  cli_data = 8'h0;
  logic        cli_valid = 1'b0;
  logic        cli_last = 1'b0;
  logic        cli_ready;
  logic [7:0]  mac_data;
  logic        mac_valid;
  logic        mac_last;

  int nchk = 0;
  int nerr = 0;
  bit ce_mode = 1'b0;
  int gate_viol = 0;

  logic [7:0] mon_d [0:511];
  logic       mon_l [0:511];
  int         mon_n = 0;

  // Each entry: {pause quantum, source address}
  localparam logic [63:0] VEC [4] = '{
    {16'h0000, 48'h02AB_CD01_2345},
    {16'hFFFF, 48'hFEDC_BA98_7654},
    {16'h1234, 48'h0000_0000_0001},
    {16'h8001, 48'hA5A5_5A5A_C3C3}
  };

  pause_tx_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .fc_en(fc_en), .tx_hold(tx_hold),
    .src_mac(src_mac), .pause_req(pause_req), .pause_val(pause_val),
    .cli_data(cli_data), .cli_valid(cli_valid), .cli_last(cli_last),
    .cli_ready(cli_ready), .mac_data(mac_data), .mac_valid(mac_valid),
    .mac_last(mac_last)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (ce_mode) ce <= ~ce;
    else         ce <= 1'b1;
  end

  always @(negedge clk) begin
    if (mac_valid && !ce) gate_viol++;
    if (mac_valid && mon_n < 512) begin
      mon_d[mon_n] = mac_data;
      mon_l[mon_n] = mac_last;
      mon_n++;
    end
  end

  initial begin
    #3_000_000;
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobe(input logic [15:0] q, input int hold);
    pause_req = 1'b1;
    pause_val = q;
    cyc(hold);
    pause_req = 1'b0;
  endtask

  task automatic send_client(input int len, input logic [7:0] base);
    int i = 0;
    while (i < len) begin
      cli_valid = 1'b1;
      cli_data  = base + 8'(i);
      cli_last  = (i == len - 1);
      @(negedge clk);
      if (cli_ready) i++;
      @(posedge clk);
      #1;
    end
    cli_valid = 1'b0;
    cli_last  = 1'b0;
  endtask

  // Independent CRC-32 model (reflected form, masked update)
  function automatic logic [31:0] model_crc(input logic [7:0] b [64]);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 60; i++) begin
      c = c ^ {24'h0, b[i]};
      for (int k = 0; k < 8; k++)
        c = (c >> 1) ^ (32'hEDB88320 & {32{c[0]}});
    end
    return ~c;
  endfunction

  task automatic check_frame(input int at, input logic [15:0] q, input logic [47:0] sa,
                             input string tag);
    logic [7:0]  e [64];
    logic [31:0] f;
    int bad = 0;
    for (int i = 0; i < 64; i++) e[i] = 8'h00;
    e[0] = 8'h01; e[1] = 8'h80; e[2] = 8'hC2; e[3] = 8'h00; e[4] = 8'h00; e[5] = 8'h01;
    for (int i = 0; i < 6; i++) e[6 + i] = sa[47 - 8*i -: 8];
    e[12] = 8'h88; e[13] = 8'h08; e[14] = 8'h00; e[15] = 8'h01;
    e[16] = q[15:8]; e[17] = q[7:0];
    f = model_crc(e);
    for (int i = 0; i < 4; i++) e[60 + i] = f[8*i +: 8];
    for (int i = 0; i < 64; i++) begin
      if (at + i >= mon_n) bad++;
      else if (mon_d[at + i] !== e[i] || mon_l[at + i] !== (i == 63)) bad++;
    end
    chk(tag, 64'(bad), 64'd0);
  endtask

  task automatic check_client(input int at, input int len, input logic [7:0] base,
                              input string tag);
    int bad = 0;
    for (int i = 0; i < len; i++) begin
      if (at + i >= mon_n) bad++;
      else if (mon_d[at + i] !== base + 8'(i) || mon_l[at + i] !== (i == len - 1)) bad++;
    end
    chk(tag, 64'(bad), 64'd0);
  endtask

  initial begin
    // R10: reset state
    cyc(3);
    chk("R10 mac_valid in reset", 64'(mac_valid), 64'd0);
    rst_n = 1'b1;
    cyc(2);
    chk("R10 mac_valid after reset", 64'(mac_valid), 64'd0);
    chk("R10 cli_ready after reset", 64'(cli_ready), 64'd1);

    // Table walk: R1 R5 R6
    for (int v = 0; v < 4; v++) begin
      src_mac = VEC[v][47:0];
      mon_n = 0;
      strobe(VEC[v][63:48], 1);
      cyc(80);
      chk("R5 frame length", 64'(mon_n), 64'd64);
      check_frame(0, VEC[v][63:48], VEC[v][47:0], "R1 R5 R6 frame content");
    end
    src_mac = 48'h02AB_CD01_2345;

    // R8: flow control off, strobe ignored, client passes
    fc_en = 1'b0;
    mon_n = 0;
    strobe(16'h7777, 1);
    send_client(10, 8'h40);
    cyc(80);
    chk("R8 strobe ignored, only client bytes", 64'(mon_n), 64'd10);
    check_client(0, 10, 8'h40, "R8 passthrough data");
    fc_en = 1'b1;

    // R2: request mid-frame, queued second client frame waits
    mon_n = 0;
    fork
      begin send_client(20, 8'h10); send_client(8, 8'hA0); end
      begin cyc(6); strobe(16'h0BAD, 1); end
    join
    cyc(10);
    chk("R2 total bytes", 64'(mon_n), 64'd92);
    check_client(0, 20, 8'h10, "R2 first client frame intact");
    check_frame(20, 16'h0BAD, src_mac, "R2 pause after first frame");
    check_client(84, 8, 8'hA0, "R2 queued frame after pause");

    // R3: several strobes collapse into one frame with latest quantum
    mon_n = 0;
    fork
      send_client(30, 8'h00);
      begin
        cyc(3); strobe(16'h1111, 1);
        cyc(3); strobe(16'h2222, 1);
        cyc(3); strobe(16'h3333, 1);
      end
    join
    cyc(80);
    chk("R3 one frame only", 64'(mon_n), 64'd94);
    check_frame(30, 16'h3333, src_mac, "R3 latest quantum");

    // R4: hold blocks client, pause still sent
    tx_hold = 1'b1;
    mon_n = 0;
    fork
      send_client(6, 8'hC0);
      begin
        cyc(5);
        chk("R4 ready low under hold", 64'(cli_ready), 64'd0);
        chk("R4 no client bytes under hold", 64'(mon_n), 64'd0);
        strobe(16'h4242, 1);
        cyc(80);
        chk("R4 pause sent under hold", 64'(mon_n), 64'd64);
        check_frame(0, 16'h4242, src_mac, "R4 pause content under hold");
        tx_hold = 1'b0;
      end
    join
    cyc(5);
    check_client(64, 6, 8'hC0, "R4 client after hold release");

    // R7: clock enable toggling
    mon_n = 0;
    gate_viol = 0;
    ce_mode = 1'b1;
    cyc(1);
    strobe(16'h5A5A, 2);
    cyc(200);
    ce_mode = 1'b0;
    cyc(2);
    chk("R7 no valid on gated cycles", 64'(gate_viol), 64'd0);
    check_frame(0, 16'h5A5A, src_mac, "R7 gated frame content");

    // R9: strobe during frame gives second frame, client held off
    mon_n = 0;
    strobe(16'hAAAA, 1);
    cyc(10);
    cli_valid = 1'b1; cli_data = 8'hEE; cli_last = 1'b1;
    @(negedge clk);
    chk("R9 ready low during pause frame", 64'(cli_ready), 64'd0);
    @(posedge clk); #1;
    cli_valid = 1'b0; cli_last = 1'b0;
    strobe(16'hBBBB, 1);
    cyc(150);
    chk("R9 two frames", 64'(mon_n), 64'd128);
    check_frame(0, 16'hAAAA, src_mac, "R9 first frame");
    check_frame(64, 16'hBBBB, src_mac, "R9 second frame");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule